// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block collects eight interrupt lines, decides which one the processor should take next, and supplies the vector for it. Software reaches it through a small register port with a one-bit address and 8-bit data. A multi-word start-up sequence on that port sets the trigger style, the vector base and the end-of-interrupt behaviour. After that sequence, writes to address 1 load the mask. Writes to address 0 are decoded by their bit patterns into end-of-interrupt, priority and read-back commands.

The controller keeps three 8-bit registers: pending requests, lines in service, and the mask. A single priority pointer names the lowest-priority line, so fixed and rotating priority use the same logic. `int_req` is raised when some unmasked pending line outranks every line in service. On a one-cycle `int_ack`, `int_vector` shows the programmed base with the line number in its low three bits, and the controller books that line as in service. A poll command lets software do the same through a plain read, with no acknowledge cycle. A line connected to a secondary controller gets no special handling. The configuration word that describes such a link is consumed and then discarded.

Top module: `irq8_ctrl`

## Requirements
- R1: After reset the controller is uninitialised. `int_req` stays low. Address 1 reads 0xFF, and writes to address 1 have no effect. Address 0 reads the pending-request register.
- R2: A write to address 0 with bit 4 = 1 starts initialisation. In that word, bit 3 = 1 selects level triggering, bit 1 = 1 means no cascade word follows, and bit 0 = 1 means a mode word follows. The write clears the in-service, pending and mask registers, restores fixed priority with line 0 highest, selects the request register for reads, and turns off automatic EOI and automatic rotation.
- R3: After the start word, the following writes to address 1 are taken in this order: the base word, then the cascade word (only if bit 1 of the start word was 0), then the mode word (only if bit 0 was 1). The cascade word does not change the mask. Once the sequence is complete, a write to address 1 loads the mask.
- R4: The vector is base-word bits 7:3 followed by the winning line number in bits 2:0.
- R5: A mask bit of 1 blocks its line. `int_req` is high exactly when some unmasked pending line ranks above every in-service line.
- R6: In edge mode, a line sets its pending bit on a low-to-high transition, and holding the line high does not request again. In level mode, the pending bit follows the line one cycle later.
- R7: An acknowledge sets the winner's in-service bit. In edge mode it also clears the winner's pending bit.
- R8: Bit 1 of the mode word enables automatic EOI, which leaves the in-service register unchanged on an acknowledge. Command code 100 (address 0, bits 7:5, with bits 4:3 = 00) makes each automatically ended line the lowest priority. Code 000 turns that off.
- R9: Code 001 clears the highest-ranked in-service bit. Code 011 clears the in-service bit named in bits 2:0.
- R10: Code 101 acts as 001 and makes the cleared line the lowest priority. Code 111 acts as 011 and makes the named line the lowest. Code 110 makes the named line the lowest without clearing anything. Code 010 changes nothing.
- R11: A write to address 0 with bits 4:3 = 01 and bits 1:0 = 10 selects the request register for reads of address 0. Bits 1:0 = 11 select the in-service register. Other values of bits 1:0 keep the current selection.
- R12: Bit 2 = 1 in that read-command write arms a poll. The next read of address 0 returns 0x80 plus the winning line number and acts as an acknowledge. It returns 0x00 if no line is requesting. The poll is then disarmed.
- R13: An in-service line blocks requests from itself and from every line ranked below it. A higher-ranked line can still interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| reg_addr | input | 1 | Register port address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the read |
| irq_line | input | 8 | Interrupt request lines |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge, one cycle per interrupt taken |
| int_vector | output | 8 | Vector, valid while int_ack is high |

## Verification
Some properties are checked on every clock cycle:
- a raised request always points at an unmasked line that is pending and not in service;
- an acknowledge books the winner in service, or leaves the in-service register unchanged when automatic EOI is on;
- a nonspecific EOI removes exactly one in-service bit;
- a start word clears state;
- an edge is never missed;
- a poll disarms after its read;
- the start-up sequence reaches the run state.

The exact vector values, the order of lines under rotation, the nesting of in-service levels, and the fact that the cascade word does not touch the mask can only be shown by the bench's scenarios.

// File: rtl/irq8_pkg.sv
package irq8_pkg;
  localparam int IRQ_LINES = 8;
  localparam int IRQ_DW    = 8;

  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_RUN
  } cfg_state_e;

  // command codes carried in bits 7:5 of an end-of-interrupt / priority write
  typedef enum logic [2:0] {
    EC_RA_CLR = 3'b000,
    EC_NS     = 3'b001,
    EC_NOP    = 3'b010,
    EC_SP     = 3'b011,
    EC_RA_SET = 3'b100,
    EC_ROT_NS = 3'b101,
    EC_SETPRI = 3'b110,
    EC_ROT_SP = 3'b111
  } eoi_code_e;
endpackage

// File: rtl/irq8_capture.sv
module irq8_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level_mode,
  input  logic         clr_all,
  input  logic [N-1:0] ack_clr,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] irr_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;
  logic [N-1:0] irr_d;

  assign rise = line_in & ~prev_q;

  // per-line next-state: level mode follows the pin, edge mode latches rises
  for (genvar g = 0; g < N; g++) begin : g_line
    assign irr_d[g] = clr_all    ? 1'b0 :
                      level_mode ? line_in[g] :
                                   (irr_q[g] & ~ack_clr[g]) | rise[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= line_in;
      irr_q  <= irr_d;
    end
  end

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !clr_all) |=> ((irr_q & $past(rise)) == $past(rise))); // R6
endmodule

// File: rtl/irq8_resolver.sv
module irq8_resolver #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  isr,
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] low_lvl,
  output logic          req_valid,
  output logic [IW-1:0] req_idx,
  output logic          isr_any,
  output logic [IW-1:0] isr_top
);
  logic [IW-1:0] idx;
  logic          blocked;

  // walk from the level just above the lowest one, wrapping round once
  always_comb begin
    req_valid = 1'b0;
    req_idx   = '0;
    isr_any   = 1'b0;
    isr_top   = '0;
    blocked   = 1'b0;
    idx       = '0;
    for (int k = 1; k <= N; k++) begin
      idx = low_lvl + IW'(k);
      if (!isr_any && isr[idx]) begin
        isr_any = 1'b1;
        isr_top = idx;
      end
      if (!req_valid && !blocked) begin
        if (isr[idx]) begin
          blocked = 1'b1;
        end else if (irr[idx] && !mask[idx]) begin
          req_valid = 1'b1;
          req_idx   = idx;
        end
      end
    end
  end
endmodule

// File: rtl/irq8_cfg.sv
module irq8_cfg
  import irq8_pkg::*;
#(
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_wr,
  input  logic          init_level,
  input  logic          init_single,
  input  logic          init_mode,
  input  logic          word_wr,
  input  logic [BW-1:0] word_base,
  input  logic          word_aeoi,
  output logic          running,
  output logic          level_mode,
  output logic          auto_eoi,
  output logic [BW-1:0] vec_base
);
  cfg_state_e    st_q, st_d;
  logic          single_q, need_mode_q;
  logic          base_en, mode_en;

  assign base_en = word_wr && (st_q == CFG_BASE);
  assign mode_en = word_wr && (st_q == CFG_MODE);
  assign running = (st_q == CFG_RUN);

  always_comb begin
    st_d = st_q;
    if (init_wr) begin
      st_d = CFG_BASE;
    end else if (word_wr) begin
      case (st_q)
        CFG_BASE: st_d = !single_q ? CFG_CASC : (need_mode_q ? CFG_MODE : CFG_RUN);
        CFG_CASC: st_d = need_mode_q ? CFG_MODE : CFG_RUN;
        CFG_MODE: st_d = CFG_RUN;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= CFG_IDLE;
      single_q    <= 1'b1;
      need_mode_q <= 1'b0;
      level_mode  <= 1'b0;
      auto_eoi    <= 1'b0;
      vec_base    <= '0;
    end else begin
      st_q <= st_d;
      if (init_wr) begin
        single_q    <= init_single;
        need_mode_q <= init_mode;
        level_mode  <= init_level;
      end
      if (init_wr || mode_en) auto_eoi <= init_wr ? 1'b0 : word_aeoi;
      if (base_en) vec_base <= word_base;
    end
  end

  AST_RUN_AFTER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (base_en && single_q && !need_mode_q && !init_wr) |=> running); // R3
endmodule

// File: rtl/irq8_ctrl.sv
module irq8_ctrl
  import irq8_pkg::*;
#(
  parameter int N_LINES = IRQ_LINES,
  parameter int DW      = IRQ_DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic [N_LINES-1:0] irq_line,
  output logic               int_req,
  input  logic               int_ack,
  output logic [DW-1:0]      int_vector
);
  localparam int IW = $clog2(N_LINES);
  localparam int BW = DW - IW;
  localparam logic [N_LINES-1:0] BIT0 = N_LINES'(1);

  // register-port decode
  logic wr0, wr1, init_wr, ocw2_wr, ocw3_wr, mask_wr, word_wr, poll_rd, take;
  logic running, level_mode, auto_eoi;
  logic [BW-1:0] vec_base;
  eoi_code_e     cmd_code;
  logic [IW-1:0] cmd_lvl;

  // state
  logic [N_LINES-1:0] irr_q, isr_q, isr_d, mask_q, mask_d;
  logic [IW-1:0]      low_q, low_d;
  logic               rot_q, rot_d, sel_isr_q, sel_isr_d, poll_q, poll_d;
  logic               isr_en, low_en, mask_en, sel_en, poll_en;

  // resolver outputs and derived one-hots
  logic               req_valid, isr_any;
  logic [IW-1:0]      req_idx, isr_top;
  logic [N_LINES-1:0] win_oh, lvl_oh, top_oh, eoi_clr, isr_set;
  logic [DW-1:0]      poll_byte;

  assign wr0      = reg_wr & ~reg_addr;
  assign wr1      = reg_wr &  reg_addr;
  assign init_wr  = wr0 & reg_wdata[4];
  assign ocw2_wr  = wr0 & running & (reg_wdata[4:3] == 2'b00);
  assign ocw3_wr  = wr0 & running & (reg_wdata[4:3] == 2'b01);
  assign mask_wr  = wr1 & running;
  assign word_wr  = wr1 & ~running;
  assign cmd_code = eoi_code_e'(reg_wdata[7:5]);
  assign cmd_lvl  = reg_wdata[IW-1:0];

  irq8_cfg #(.BW(BW)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_wr     (init_wr),
    .init_level  (reg_wdata[3]),
    .init_single (reg_wdata[1]),
    .init_mode   (reg_wdata[0]),
    .word_wr     (word_wr),
    .word_base   (reg_wdata[DW-1:IW]),
    .word_aeoi   (reg_wdata[1]),
    .running     (running),
    .level_mode  (level_mode),
    .auto_eoi    (auto_eoi),
    .vec_base    (vec_base)
  );

  irq8_capture #(.N(N_LINES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_mode (level_mode),
    .clr_all    (init_wr),
    .ack_clr    (win_oh),
    .line_in    (irq_line),
    .irr_q      (irr_q)
  );

  irq8_resolver #(.N(N_LINES), .IW(IW)) u_res (
    .irr       (irr_q),
    .isr       (isr_q),
    .mask      (mask_q),
    .low_lvl   (low_q),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .isr_any   (isr_any),
    .isr_top   (isr_top)
  );

  assign int_req    = running & req_valid;
  assign int_vector = {vec_base, req_idx};
  assign poll_rd    = reg_rd & ~reg_addr & poll_q;
  assign take       = int_req & (int_ack | poll_rd);
  assign win_oh     = take ? (BIT0 << req_idx) : '0;
  assign lvl_oh     = BIT0 << cmd_lvl;
  assign top_oh     = isr_any ? (BIT0 << isr_top) : '0;
  assign isr_set    = (take && !auto_eoi) ? win_oh : '0;
  assign poll_byte  = int_req ? {1'b1, {(DW-1-IW){1'b0}}, req_idx} : '0;

  assign reg_rdata  = reg_addr  ? mask_q    :
                      poll_q    ? poll_byte :
                      sel_isr_q ? isr_q     : irr_q;

  // next-state for in-service, priority pointer and rotate-on-auto flag
  always_comb begin
    eoi_clr = '0;
    low_d   = low_q;
    rot_d   = rot_q;
    if (take && auto_eoi && rot_q) low_d = req_idx;
    if (ocw2_wr) begin
      case (cmd_code)
        EC_NS:     eoi_clr = top_oh;
        EC_ROT_NS: begin
          eoi_clr = top_oh;
          if (isr_any) low_d = isr_top;
        end
        EC_SP:     eoi_clr = lvl_oh;
        EC_ROT_SP: begin
          eoi_clr = lvl_oh;
          low_d   = cmd_lvl;
        end
        EC_SETPRI: low_d = cmd_lvl;
        EC_RA_SET: rot_d = 1'b1;
        EC_RA_CLR: rot_d = 1'b0;
        default:   ;
      endcase
    end
    if (init_wr) begin
      low_d = '1;
      rot_d = 1'b0;
    end
  end

  assign isr_d     = init_wr ? '0 : ((isr_q | isr_set) & ~eoi_clr);
  assign mask_d    = init_wr ? '0 : reg_wdata;
  assign sel_isr_d = init_wr ? 1'b0 : reg_wdata[0];
  assign poll_d    = init_wr ? 1'b0 : (ocw3_wr ? reg_wdata[2] : 1'b0);

  assign isr_en  = init_wr | take | ocw2_wr;
  assign low_en  = init_wr | take | ocw2_wr;
  assign mask_en = init_wr | mask_wr;
  assign sel_en  = init_wr | (ocw3_wr & reg_wdata[1]);
  assign poll_en = init_wr | ocw3_wr | poll_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q     <= '0;
      mask_q    <= '1;
      low_q     <= '1;
      rot_q     <= 1'b0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      if (isr_en)  isr_q     <= isr_d;
      if (low_en)  low_q     <= low_d;
      if (low_en)  rot_q     <= rot_d;
      if (mask_en) mask_q    <= mask_d;
      if (sel_en)  sel_isr_q <= sel_isr_d;
      if (poll_en) poll_q    <= poll_d;
    end
  end

  AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (irr_q[req_idx] && !mask_q[req_idx] && !isr_q[req_idx])); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (isr_q == '0 && mask_q == '0)); // R2
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !auto_eoi && !ocw2_wr && !init_wr) |=> ((isr_q & $past(win_oh)) != '0)); // R7
  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && auto_eoi && !ocw2_wr && !init_wr) |=> (isr_q == $past(isr_q))); // R8
  AST_NS_EOI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ocw2_wr && cmd_code == EC_NS && isr_q != '0 && !take)
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R9
  AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !ocw3_wr) |=> !poll_q); // R12
endmodule

// File: tb/tb_irq8_ctrl.sv
module tb_irq8_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2,
                         OP_IN = 3'd3, OP_ACK = 3'd4, OP_INT = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic       addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } step_t;

  localparam int NSTEP = 36;
  localparam step_t TBL [NSTEP] = '{
    '{OP_WR,  1'b0, 8'h13, 8'h00, 4'd2},  // R2 start: edge, no cascade word, mode word follows
    '{OP_WR,  1'b1, 8'h40, 8'h00, 4'd3},  // R3 base word
    '{OP_WR,  1'b1, 8'h01, 8'h00, 4'd3},  // R3 mode word, no auto EOI
    '{OP_RD,  1'b1, 8'h00, 8'h00, 4'd2},  // R2 mask cleared by the start word
    '{OP_WR,  1'b1, 8'h04, 8'h00, 4'd5},  // R5 mask line 2
    '{OP_IN,  1'b0, 8'h04, 8'h00, 4'd6},  // R6 rise on line 2
    '{OP_INT, 1'b0, 8'h00, 8'h00, 4'd5},  // R5 masked line gives no request
    '{OP_RD,  1'b0, 8'h00, 8'h04, 4'd11}, // R11 request register read by default
    '{OP_IN,  1'b0, 8'h0C, 8'h00, 4'd6},  // R6 rise on line 3
    '{OP_INT, 1'b0, 8'h00, 8'h01, 4'd5},
    '{OP_ACK, 1'b0, 8'h00, 8'h43, 4'd4},  // R4 vector base 0x40 plus line 3
    '{OP_WR,  1'b0, 8'h0B, 8'h00, 4'd11}, // R11 select in-service
    '{OP_RD,  1'b0, 8'h00, 8'h08, 4'd7},  // R7 line 3 in service
    '{OP_WR,  1'b0, 8'h0A, 8'h00, 4'd11}, // R11 select requests
    '{OP_RD,  1'b0, 8'h00, 8'h04, 4'd7},  // R7 line 3 request cleared
    '{OP_IN,  1'b0, 8'h0D, 8'h00, 4'd6},  // rise on line 0
    '{OP_INT, 1'b0, 8'h00, 8'h01, 4'd13}, // R13 higher line nests
    '{OP_ACK, 1'b0, 8'h00, 8'h40, 4'd4},
    '{OP_IN,  1'b0, 8'h2D, 8'h00, 4'd6},  // rise on line 5
    '{OP_INT, 1'b0, 8'h00, 8'h00, 4'd13}, // R13 lower line blocked
    '{OP_WR,  1'b0, 8'h20, 8'h00, 4'd9},  // R9 nonspecific EOI ends line 0
    '{OP_INT, 1'b0, 8'h00, 8'h00, 4'd13}, // R13 line 3 still blocks line 5
    '{OP_WR,  1'b0, 8'h63, 8'h00, 4'd9},  // R9 specific EOI line 3
    '{OP_INT, 1'b0, 8'h00, 8'h01, 4'd9},
    '{OP_WR,  1'b0, 8'h0B, 8'h00, 4'd11},
    '{OP_RD,  1'b0, 8'h00, 8'h00, 4'd9},  // R9 nothing left in service
    '{OP_ACK, 1'b0, 8'h00, 8'h45, 4'd4},
    '{OP_WR,  1'b0, 8'hE5, 8'h00, 4'd10}, // R10 rotate on specific EOI, line 5 lowest
    '{OP_WR,  1'b1, 8'h00, 8'h00, 4'd5},  // unmask everything
    '{OP_IN,  1'b0, 8'hAD, 8'h00, 4'd6},  // rise on line 7
    '{OP_INT, 1'b0, 8'h00, 8'h01, 4'd10},
    '{OP_ACK, 1'b0, 8'h00, 8'h47, 4'd10}, // R10 line 7 outranks line 2 now
    '{OP_WR,  1'b0, 8'h20, 8'h00, 4'd10}, // nonspecific EOI under rotation ends line 7
    '{OP_ACK, 1'b0, 8'h00, 8'h42, 4'd10},
    '{OP_WR,  1'b0, 8'h40, 8'h00, 4'd10}, // R10 no-op command
    '{OP_RD,  1'b0, 8'h00, 8'h04, 4'd10}  // R10 in-service untouched by no-op
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, int_ack = 1'b0;
  logic [7:0] reg_wdata = 8'h00, irq_line = 8'h00;
  logic [7:0] reg_rdata, int_vector;
  logic       int_req;
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq8_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_line   (irq_line),
    .int_req    (int_req),
    .int_ack    (int_ack),
    .int_vector (int_vector)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic a, input logic [7:0] d,
                       input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; int_ack = 1'b0;
    reg_addr = a; reg_wdata = d;
    case (op)
      OP_WR:   reg_wr = 1'b1;
      OP_RD:   reg_rd = 1'b1;
      OP_IN:   irq_line = d;
      OP_ACK:  int_ack = 1'b1;
      default: ;
    endcase
    #1;
    case (op)
      OP_RD:   check(tag, reg_rdata, e);
      OP_ACK:  check(tag, int_vector, e);
      OP_INT:  check(tag, {7'd0, int_req}, e);
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state before any start word
    apply(OP_INT, 1'b0, 8'h00, 8'h00, "R1 int_req low");
    apply(OP_RD,  1'b1, 8'h00, 8'hFF, "R1 mask reset");
    apply(OP_WR,  1'b1, 8'h00, 8'h00, "R1");
    apply(OP_RD,  1'b1, 8'h00, 8'hFF, "R1 mask write ignored");
    apply(OP_RD,  1'b0, 8'h00, 8'h00, "R1 request read");

    for (int i = 0; i < NSTEP; i++)
      apply(TBL[i].op, TBL[i].addr, TBL[i].data, TBL[i].exp,
            $sformatf("R%0d step %0d", TBL[i].req, i));

    // level triggering with automatic EOI and automatic rotation
    apply(OP_IN,  1'b0, 8'h00, 8'h00, "");
    apply(OP_WR,  1'b0, 8'h1B, 8'h00, "R2");
    apply(OP_WR,  1'b1, 8'h88, 8'h00, "R3");
    apply(OP_WR,  1'b1, 8'h02, 8'h00, "R3");
    apply(OP_RD,  1'b1, 8'h00, 8'h00, "R2 mask after restart");
    apply(OP_IN,  1'b0, 8'h02, 8'h00, "");
    apply(OP_INT, 1'b0, 8'h00, 8'h01, "R6 level request");
    apply(OP_ACK, 1'b0, 8'h00, 8'h89, "R4 vector");
    apply(OP_WR,  1'b0, 8'h0B, 8'h00, "R11");
    apply(OP_RD,  1'b0, 8'h00, 8'h00, "R8 auto EOI leaves no in-service bit");
    apply(OP_INT, 1'b0, 8'h00, 8'h01, "R6 level still high");
    apply(OP_IN,  1'b0, 8'h00, 8'h00, "");
    apply(OP_INT, 1'b0, 8'h00, 8'h00, "R6 level withdrawn");
    apply(OP_WR,  1'b0, 8'h80, 8'h00, "R8 rotate in auto EOI on");
    apply(OP_IN,  1'b0, 8'h06, 8'h00, "");
    apply(OP_ACK, 1'b0, 8'h00, 8'h89, "R8 first");
    apply(OP_ACK, 1'b0, 8'h00, 8'h8A, "R8 rotated");
    apply(OP_ACK, 1'b0, 8'h00, 8'h89, "R8 rotated back");
    apply(OP_WR,  1'b0, 8'h00, 8'h00, "R8 rotate in auto EOI off");
    apply(OP_ACK, 1'b0, 8'h00, 8'h8A, "R8 no rotation");
    apply(OP_ACK, 1'b0, 8'h00, 8'h8A, "R8 still no rotation");
    apply(OP_IN,  1'b0, 8'h00, 8'h00, "");
    apply(OP_IN,  1'b0, 8'h10, 8'h00, "");
    apply(OP_WR,  1'b0, 8'h0C, 8'h00, "R12 arm poll");
    apply(OP_RD,  1'b0, 8'h00, 8'h84, "R12 poll line 4");
    apply(OP_IN,  1'b0, 8'h00, 8'h00, "");
    apply(OP_WR,  1'b0, 8'h0C, 8'h00, "R12 arm poll");
    apply(OP_RD,  1'b0, 8'h00, 8'h00, "R12 poll empty");

    // edge triggering with a cascade word, poll as acknowledge
    apply(OP_WR,  1'b0, 8'h10, 8'h00, "R2");
    apply(OP_WR,  1'b1, 8'h20, 8'h00, "R3 base");
    apply(OP_WR,  1'b1, 8'hFF, 8'h00, "R3 cascade word");
    apply(OP_RD,  1'b1, 8'h00, 8'h00, "R3 cascade word not mask");
    apply(OP_WR,  1'b1, 8'h0F, 8'h00, "R3 mask in run state");
    apply(OP_RD,  1'b1, 8'h00, 8'h0F, "R3 mask loaded");
    apply(OP_IN,  1'b0, 8'h40, 8'h00, "");
    apply(OP_WR,  1'b0, 8'h0C, 8'h00, "R12 arm poll");
    apply(OP_RD,  1'b0, 8'h00, 8'h86, "R12 poll line 6");
    apply(OP_WR,  1'b0, 8'h0B, 8'h00, "R11");
    apply(OP_RD,  1'b0, 8'h00, 8'h40, "R12 poll booked line 6");
    apply(OP_WR,  1'b0, 8'h20, 8'h00, "R9");
    apply(OP_INT, 1'b0, 8'h00, 8'h00, "R6 held edge line does not repeat");
    apply(OP_RD,  1'b0, 8'h00, 8'h00, "R9 in-service cleared");
    apply(OP_IN,  1'b0, 8'h41, 8'h00, "");
    apply(OP_INT, 1'b0, 8'h00, 8'h00, "R5 masked line 0");
    apply(OP_IDLE, 1'b0, 8'h00, 8'h00, "");

    done = 1'b1;
    finish_run();
  end
endmodule